// File: doc/BRIEF.md
# Wait Release Edge Detector

This block watches four external wait/ready lines and reports when the line used as a NAND ready monitor goes from busy back to ready. Each raw line first passes through a synchroniser into the functional clock domain. A per-pin polarity bit then decides which level means busy. A saturating counter measures how long the line has been busy. A return to the idle level counts as a release only if the line was busy for at least two clock cycles before it.

Each release sets a sticky status bit that software reads by polling. Software clears the bit by writing a one to its clear strobe. The single interrupt line combines the status bits that are enabled.

Clearing a status bit while the device is still busy does not disturb the busy counter, so the next release is still caught. The timing that governs wait states of normal memory accesses plays no part here. That timing has no input on this block.

Top module: `wait_release_det`

## Requirements
- R1: Each pin is synchronised with two flops. A qualified release becomes visible on `status[i]` after the third rising clock edge that samples the raw pin at its idle level. After the second such edge it is not yet visible.
- R2: A release is recognised only if the synchronised pin was busy for at least two consecutive clock cycles. A busy pulse that one clock edge samples sets no status.
- R3: `busy_high[i]=1` makes a high level on `wait_in[i]` the busy level. `busy_high[i]=0` makes a low level the busy level.
- R4: A set status bit stays set until `clear_w1c[i]` is high at a rising edge, and that edge clears it.
- R5: When a new release and a clear of the same pin meet at the same edge, the status bit ends up set.
- R6: A clear given while the pin is still busy does not prevent the following release from setting the status bit.
- R7: `irq` is high exactly when some pin has both `status[i]` and `irq_en[i]` set. Status bits are set whatever the enable bits hold.
- R8: The busy counter saturates, so a release after a busy period of any length (for example 40 cycles) is recognised.
- R9: After reset, all status bits and `irq` are 0. No release is reported until the synchroniser has refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wait_in | input | 4 | Raw external wait/ready lines |
| busy_high | input | 4 | Per-pin polarity: 1 means high is busy |
| irq_en | input | 4 | Per-pin interrupt enable |
| clear_w1c | input | 4 | Per-pin write-one-to-clear strobe for the status bit |
| status | output | 4 | Sticky release-detected flags |
| irq | output | 1 | OR of enabled status bits |

## Verification
A raw level change reaches the status register on the third rising edge after the bench drives it. The two synchroniser flops account for two edges and the status flop for the third. A clear strobe acts on the first edge after it is driven. `irq` follows `status` in the same cycle with no extra register. The bench drives all inputs on falling edges and reads outputs on the following falling edges. Each directed check counts exactly that many falling edges, and it checks both the cycle before the result is due and the cycle it is due. During random stimulus, a cycle-level reference updated on every rising edge is compared against `status` and `irq` at every falling edge.

// File: rtl/wrd_pkg.sv
package wrd_pkg;
  // Width of a counter that must reach the value 'limit'.
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/wrd_rst_sync.sv
module wrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/wrd_sync.sv
module wrd_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         primed
);
  logic [STAGES-1:0][N-1:0] stg_q;
  logic [STAGES-1:0][N-1:0] stg_d;
  logic [STAGES-1:0]        fill_q;
  logic [STAGES-1:0]        fill_d;

  always_comb begin
    stg_d[0]  = d;
    fill_d[0] = 1'b1;
    for (int k = 1; k < STAGES; k++) begin
      stg_d[k]  = stg_q[k-1];
      fill_d[k] = fill_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      fill_q <= '0;
    end else begin
      stg_q  <= stg_d;
      fill_q <= fill_d;
    end
  end

  assign q      = stg_q[STAGES-1];
  assign primed = fill_q[STAGES-1];
endmodule

// File: rtl/wrd_qual.sv
module wrd_qual #(
  parameter int N          = 4,
  parameter int MIN_ACTIVE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] busy_high,
  input  logic         primed,
  output logic [N-1:0] busy,
  output logic [N-1:0] rel
);
  localparam int CW = wrd_pkg::cnt_bits(MIN_ACTIVE);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_ACTIVE);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_en;

    assign busy[g] = primed & ~(lvl[g] ^ busy_high[g]);
    assign rel[g]  = primed & ~busy[g] & (cnt_q >= CNT_MAX);

    always_comb begin
      cnt_en = 1'b1;
      if (!busy[g])             cnt_d = '0;
      else if (cnt_q < CNT_MAX) cnt_d = cnt_q + 1'b1;
      else begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wrd_flags.sv
module wrd_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rel,
  input  logic [N-1:0] clear_w1c,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic         flag_en;

  always_comb begin
    // a fresh release has priority over a clear of the same bit
    flag_d  = rel | (flag_q & ~clear_w1c);
    flag_en = |rel | |clear_w1c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign status = flag_q;
  assign irq    = |(flag_q & irq_en);
endmodule

// File: rtl/wait_release_det.sv
module wait_release_det #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_ACTIVE  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] wait_in,
  input  logic [NUM_PINS-1:0] busy_high,
  input  logic [NUM_PINS-1:0] irq_en,
  input  logic [NUM_PINS-1:0] clear_w1c,
  output logic [NUM_PINS-1:0] status,
  output logic                irq
);
  logic                rst_q_n;
  logic [NUM_PINS-1:0] lvl;
  logic                primed;
  logic [NUM_PINS-1:0] busy;
  logic [NUM_PINS-1:0] rel;

  wrd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  wrd_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .d      (wait_in),
    .q      (lvl),
    .primed (primed)
  );

  wrd_qual #(.N(NUM_PINS), .MIN_ACTIVE(MIN_ACTIVE)) u_qual (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lvl       (lvl),
    .busy_high (busy_high),
    .primed    (primed),
    .busy      (busy),
    .rel       (rel)
  );

  wrd_flags #(.N(NUM_PINS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rel       (rel),
    .clear_w1c (clear_w1c),
    .irq_en    (irq_en),
    .status    (status),
    .irq       (irq)
  );
endmodule

// File: rtl/wrd_checker.sv
module wrd_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status,
  input logic         irq,
  input logic [N-1:0] irq_en,
  input logic [N-1:0] clear_w1c,
  input logic [N-1:0] busy,
  input logic [N-1:0] rel
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(clear_w1c) & ~status) == '0)); // R4

  AST_SET_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(rel)) == '0)); // R2

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq); // R7

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq); // R7

  for (genvar g = 0; g < N; g++) begin : g_pin
    AST_REL_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rel[g] |-> ($past(busy[g]) && $past(busy[g], 2))); // R2

    AST_DET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rel[g] |=> status[g]); // R5
  end
endmodule

bind wait_release_det wrd_checker #(.N(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .status    (status),
  .irq       (irq),
  .irq_en    (irq_en),
  .clear_w1c (clear_w1c),
  .busy      (busy),
  .rel       (rel)
);

// File: tb/wait_release_det_bench.sv
`timescale 1ns/1ps
module wait_release_det_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] wait_in, busy_high, irq_en, clear_w1c;
  logic [3:0] status;
  logic       irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  logic [3:0] m_s1, m_s2, m_stat;
  int         m_cnt [4];

  always #2.5 clk = ~clk;

  wait_release_det u_wait_release_det (
    .clk(clk), .rst_n(rst_n), .wait_in(wait_in), .busy_high(busy_high),
    .irq_en(irq_en), .clear_w1c(clear_w1c), .status(status), .irq(irq)
  );

  function automatic logic exp_irq(input logic [3:0] st, input logic [3:0] en);
    return |(st & en);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_clear(input logic [3:0] m);
    clear_w1c = m; tick(); clear_w1c = '0;
  endtask

  // reference: raw level -> two stages -> busy count -> sticky flag
  always @(posedge clk) begin
    cyc++;
    if (model_on) begin
      logic [3:0] ns;
      for (int i = 0; i < 4; i++) begin
        logic b;
        b = busy_high[i] ? m_s2[i] : ~m_s2[i];
        ns[i] = (!b && m_cnt[i] >= 2) | (m_stat[i] & ~clear_w1c[i]);
        m_cnt[i] = b ? ((m_cnt[i] < 2) ? m_cnt[i] + 1 : 2) : 0;
      end
      m_stat = ns;
      m_s2 = m_s1;
      m_s1 = wait_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R1/R3 model status", {28'd0, status}, {28'd0, m_stat});
      chk("R7 model irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, irq_en)});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; wait_in = '0; busy_high = 4'hF; irq_en = '0; clear_w1c = '0;
    m_s1 = '0; m_s2 = '0; m_stat = '0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    tick(5);
    chk("R9 reset status", {28'd0, status}, 32'd0);
    rst_n = 1'b1;
    tick(6);
    chk("R9 status after reset", {28'd0, status}, 32'd0);
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    model_on = 1'b1;

    // R2: single sampled busy cycle is rejected
    wait_in[0] = 1'b1; tick(); wait_in[0] = 1'b0; tick(5);
    chk("R2 short pulse", {31'd0, status[0]}, 32'd0);

    // R1: two busy cycles qualify; visible on third edge
    wait_in[0] = 1'b1; tick(2); wait_in[0] = 1'b0; tick(2);
    chk("R1 not yet", {31'd0, status[0]}, 32'd0);
    tick();
    chk("R1 visible", {31'd0, status[0]}, 32'd1);
    chk("R7 poll without enable", {31'd0, irq}, 32'd0);

    // R4 / R7: sticky, interrupt gating, clear
    tick(10);
    chk("R4 sticky", {31'd0, status[0]}, 32'd1);
    irq_en = 4'b0001; tick();
    chk("R7 irq enabled", {31'd0, irq}, 32'd1);
    irq_en = 4'b0010; tick();
    chk("R7 other enable", {31'd0, irq}, 32'd0);
    irq_en = 4'b0001;
    pulse_clear(4'b0001);
    chk("R4 cleared", {31'd0, status[0]}, 32'd0);
    chk("R7 irq after clear", {31'd0, irq}, 32'd0);
    irq_en = '0;

    // R6: clear during busy does not block the next release
    wait_in[1] = 1'b1; tick(3); wait_in[1] = 1'b0; tick(3);
    chk("R6 first release", {31'd0, status[1]}, 32'd1);
    wait_in[1] = 1'b1; tick(4);
    pulse_clear(4'b0010);
    chk("R6 cleared while busy", {31'd0, status[1]}, 32'd0);
    tick(3); wait_in[1] = 1'b0; tick(3);
    chk("R6 release after clear", {31'd0, status[1]}, 32'd1);

    // R5: detection and clear at the same edge
    wait_in[2] = 1'b1; tick(2); wait_in[2] = 1'b0; tick(3);
    wait_in[2] = 1'b1; tick(3); wait_in[2] = 1'b0; tick(2);
    chk("R5 still set from before", {31'd0, status[2]}, 32'd1);
    pulse_clear(4'b0100);
    chk("R5 detection wins", {31'd0, status[2]}, 32'd1);
    pulse_clear(4'b0100);
    chk("R5 plain clear", {31'd0, status[2]}, 32'd0);

    // R3: busy level low on pin 3
    busy_high[3] = 1'b0; wait_in[3] = 1'b1; tick(6);
    pulse_clear(4'b1000);
    chk("R3 idle high", {31'd0, status[3]}, 32'd0);
    wait_in[3] = 1'b0; tick(); wait_in[3] = 1'b1; tick(5);
    chk("R3 short low rejected", {31'd0, status[3]}, 32'd0);
    wait_in[3] = 1'b0; tick(3); wait_in[3] = 1'b1; tick(2);
    chk("R3 not yet", {31'd0, status[3]}, 32'd0);
    tick();
    chk("R3 low-busy release", {31'd0, status[3]}, 32'd1);
    pulse_clear(4'b1000);

    // R8: long busy period
    pulse_clear(4'b1111);
    wait_in[0] = 1'b1; tick(40); wait_in[0] = 1'b0; tick(3);
    chk("R8 long busy", {31'd0, status[0]}, 32'd1);
    irq_en = 4'b1110; tick();
    chk("R7 masked pin0", {31'd0, irq}, 32'd0);
    pulse_clear(4'b1111);

    // random phase, checked against the reference every cycle
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 4; i++)
        if ($urandom % 4 == 0) wait_in[i] = ~wait_in[i];
      clear_w1c = 4'($urandom) & 4'($urandom) & 4'($urandom);
      if ($urandom % 64 == 0) irq_en = 4'($urandom);
      if ($urandom % 700 == 0) busy_high = 4'($urandom);
      tick();
    end
    clear_w1c = '0;
    tick(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule